// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block sits on the read side of a byte-wide nonvolatile memory model. While the memory runs an internally timed page program or a whole-array erase, it puts status information on the read data in place of array contents. Software can then poll the device until the operation completes. When no operation is running, the block passes the array's byte through unchanged.

During a page program, bit 7 of every read is the inverse of bit 7 of the most recently loaded byte. Bit 6 changes value on every read strobe. The first status read of each new operation shows a 1 on bit 6. During an erase only the alternating bit carries meaning: bits 7 and 6 both show the toggle state and bits 5:0 read as ones. Read data is registered. It is updated one clock after a strobe and holds between strobes.

Top module: `wstat_rdmux`

## Requirements
- R1: After reset, `rd_data` is 8'hFF.
- R2: A strobe taken while `busy` is low makes `rd_data` equal to `arr_data` (as sampled with the strobe) on the following clock.
- R3: A strobe taken while `busy` is high and `op_erase` is low yields `rd_data[7]` equal to the inverse of `ld_data[7]`.
- R4: While `busy` stays high, bit 6 of successive reads alternates on each strobe, whatever the number of clocks between strobes; clocks without a strobe do not advance it.
- R5: The first read strobe after `busy` rises returns bit 6 as 1, including a strobe in the same clock in which `busy` rises.
- R6: A strobe taken while `busy` and `op_erase` are both high yields `rd_data[7]` equal to `rd_data[6]` (the toggle state) and `rd_data[5:0]` equal to 6'h3F.
- R7: During a page program, a read at `rd_addr == ld_addr` returns `ld_data[5:0]` on bits 5:0; a read at any other address returns 6'h3F there.
- R8: `rd_data` does not change in a clock that follows a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Read access strobe, one clock per read |
| rd_addr | input | AW | Address of the read |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | 1 = running operation is an erase, 0 = page program |
| ld_addr | input | AW | Address of the last loaded byte |
| ld_data | input | 8 | Value of the last loaded byte |
| arr_data | input | 8 | Array byte at `rd_addr` |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions check on every cycle that the output holds between strobes. On each strobe they check the inverted polling bit, the idle pass-through, the erase encoding, the alternation of bit 6 across back-to-back busy strobes, and a 1 on the first read after busy rises. Only the bench scenarios can show that the alternation survives gaps of idle clocks between reads. They also show that an operation ending and a new one starting restarts the toggle, and that the address comparison selects loaded bits or filler.

// File: rtl/wstat_rdmux.sv
module wstat_rdmux #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic          busy,
  input  logic          op_erase,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic [7:0]    arr_data,
  output logic [7:0]    rd_data
);

  logic busy_q;
  logic tog;
  logic tog_now;
  logic hit;
  logic [7:0] stat_pg;
  logic [7:0] stat_er;
  logic [7:0] nxt;

  assign tog_now = (busy && !busy_q) ? 1'b1 : tog;
  assign hit     = (rd_addr == ld_addr);
  assign stat_pg = {~ld_data[7], tog_now, hit ? ld_data[5:0] : 6'h3F};
  assign stat_er = {tog_now, tog_now, 6'h3F};
  assign nxt     = !busy ? arr_data : (op_erase ? stat_er : stat_pg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tog     <= 1'b1;
      rd_data <= 8'hFF;
    end else begin
      busy_q <= busy;
      if (busy && !busy_q && !rd_stb) tog <= 1'b1;
      else if (busy && rd_stb)        tog <= ~tog_now;
      if (rd_stb) rd_data <= nxt;
    end
  end

endmodule

module wstat_rdmux_chk #(
  parameter int AW = 17
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       busy,
  input logic       op_erase,
  input logic [7:0] ld_data,
  input logic [7:0] arr_data,
  input logic [7:0] rd_data
);

  logic seen_busy;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_busy <= 1'b0;
    else        seen_busy <= busy;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy) |=> rd_data == $past(arr_data));

  p_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && !op_erase) |=> rd_data[7] == !$past(ld_data[7]));

  p_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && !seen_busy) |=> rd_data[6]);

  p_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && seen_busy && $past(rd_stb && busy)) |=> rd_data[6] != $past(rd_data[6]));

  p_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && op_erase) |=> (rd_data[7] == rd_data[6]) && (rd_data[5:0] == 6'h3F));

endmodule

bind wstat_rdmux wstat_rdmux_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy), .op_erase(op_erase),
  .ld_data(ld_data), .arr_data(arr_data), .rd_data(rd_data)
);

// File: tb/test_wstat_rdmux.sv
module test_wstat_rdmux;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          busy = 1'b0;
  logic          op_erase = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = 8'h00;
  logic [7:0]    arr_data = 8'h00;
  logic [7:0]    rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit m_tog = 1'b1;
  logic [7:0] m_last = 8'hFF;

  always #10 clk = ~clk;

  wstat_rdmux #(.AW(AW)) i_wstat_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr), .busy(busy),
    .op_erase(op_erase), .ld_addr(ld_addr), .ld_data(ld_data),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [AW-1:0] a);
    if (!busy) return arr_data;
    if (op_erase) return {m_tog, m_tog, 6'h3F};
    return {~ld_data[7], m_tog, (a == ld_addr) ? ld_data[5:0] : 6'h3F};
  endfunction

  task automatic do_read(input logic [AW-1:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    rd_addr = a;
    rd_stb = 1'b1;
    e = model(a);
    if (busy) m_tog = ~m_tog;
    @(negedge clk);
    rd_stb = 1'b0;
    m_last = e;
    check(req, rd_data, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R8", rd_data, m_last);
    end
  endtask

  task automatic start_op(input bit er);
    @(negedge clk);
    busy = 1'b1;
    op_erase = er;
    m_tog = 1'b1;
  endtask

  task automatic end_op();
    @(negedge clk);
    busy = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'hFF);
    rst_n = 1'b1;
    m_last = 8'hFF;
    idle(2);

    arr_data = 8'h5A;
    do_read(17'h00010, "R2");
    arr_data = 8'hC3;
    idle(3);

    ld_addr = 17'h00205;
    ld_data = 8'h96;
    start_op(1'b0);
    do_read(17'h00205, "R5 R3 R7");
    do_read(17'h00205, "R4 R3");
    idle(4);
    do_read(17'h00206, "R4 R7");
    do_read(17'h00205, "R4");
    ld_data = 8'h17;
    do_read(17'h00205, "R3 R7");
    end_op();
    arr_data = 8'h17;
    do_read(17'h00205, "R2");

    @(negedge clk);
    busy = 1'b1;
    op_erase = 1'b1;
    m_tog = 1'b1;
    rd_addr = 17'h1FFFF;
    rd_stb = 1'b1;
    m_last = model(17'h1FFFF);
    m_tog = ~m_tog;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R5 R6", rd_data, m_last);
    do_read(17'h00000, "R6 R4");
    idle(2);
    do_read(17'h00001, "R6 R4");
    end_op();
    arr_data = 8'hFF;
    do_read(17'h00001, "R2");

    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r < 5) begin
        do_read(($urandom_range(0, 1) == 0) ? ld_addr : AW'($urandom), "R2 R3 R4 R6 R7");
      end else if (r == 5) begin
        idle($urandom_range(1, 3));
      end else if (r == 6) begin
        if (busy) end_op();
        else start_op(1'($urandom));
      end else begin
        @(negedge clk);
        arr_data = 8'($urandom);
        ld_data = 8'($urandom);
        if ($urandom_range(0, 3) == 0) ld_addr = AW'($urandom);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule